// File: doc/BRIEF.md
# Code Section Cycle Profiler

The profiler watches the program counter of a processor core and measures how many clock cycles elapse between the moment execution reaches a chosen start address and the moment it reaches a chosen end address. Every clock between those two points is counted. This includes each pass of a loop inside the section, stalls and cycles in which the PC is not valid.

Each completed measurement updates a set of running statistics: the most recent count, the smallest and largest counts seen, the number of completed measurements, the sum of all counts, and their mean. A small sequential divider computes the mean and flags it valid once the division has settled. A clear input wipes the statistics, so results from earlier experiments do not mix with new ones. Counters and sums stick at their all-ones value instead of wrapping.

Top module: `section_profiler`

## Requirements
- R1: After reset, and in the cycle after `stats_clr` is high, `min_cycles` is all ones; `max_cycles`, `last_cycles`, `trig_count`, `total_cycles` and `avg_cycles` are zero; and `avg_valid` is low.
- R2: A measurement equals the number of clock edges from the edge that samples the start address to the edge that samples the end address. Every cycle in between counts, whatever the PC holds and whether `pc_valid` is high or low.
- R3: An end address sampled while no section is being timed has no effect. A PC presented while `pc_valid` is low never starts, restarts or ends a measurement.
- R4: If the start address is sampled again while timing, the count restarts from that edge.
- R5: `min_cycles` and `max_cycles` hold the smallest and largest measurements since the last reset or clear.
- R6: Each completed measurement raises `trig_count` by one, places its value in `last_cycles` and adds it to `total_cycles`.
- R7: `avg_cycles` equals floor(`total_cycles` / `trig_count`). `avg_valid` is low from the second clock edge after the end edge. It rises on edge CNT_W+4, counting the end edge as edge 1, which is one cycle after the divider finishes.
- R8: The measurement, `trig_count` and `total_cycles` saturate at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_valid | input | 1 | PC value is valid this cycle |
| pc | input | ADDR_W | Current program counter |
| start_addr | input | ADDR_W | Address that begins a timed section |
| end_addr | input | ADDR_W | Address that closes a timed section |
| stats_clr | input | 1 | Clear all statistics |
| last_cycles | output | CNT_W | Most recent measurement |
| min_cycles | output | CNT_W | Smallest measurement |
| max_cycles | output | CNT_W | Largest measurement |
| trig_count | output | CNT_W | Number of completed measurements |
| total_cycles | output | CNT_W | Sum of all measurements |
| avg_cycles | output | CNT_W | Mean measurement |
| avg_valid | output | 1 | Mean is up to date |

## Verification
Sections are driven with three kinds of filler between start and end:
- a constant unrelated PC, which checks plain counting;
- an alternating loop-body PC, which shows that repeated passes all accumulate;
- cycles with `pc_valid` low that carry the start and end addresses, which separates counting of invalid cycles from the address decoding.

Further runs restart a section midway, present a lone end address, and clear the statistics. Runs longer than the counter range and a long series of one-cycle sections push the measurement, the trigger count and the sum into saturation. At every measurement, the latency of `avg_valid` shows whether the divider and the valid flag are timed correctly.

// File: rtl/cprof_pkg.sv
package cprof_pkg;
    localparam int unsigned ADDR_W_DEF = 16;
    localparam int unsigned CNT_W_DEF  = 32;

    typedef enum logic {
        WIN_IDLE,
        WIN_TIMING
    } win_state_e;

    typedef enum logic {
        DIV_IDLE,
        DIV_RUN
    } div_state_e;
endpackage

// File: rtl/cprof_window.sv
module cprof_window
    import cprof_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_valid,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              meas_done,
    output logic [CNT_W-1:0]  meas_val
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    win_state_e       state_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_inc;
    logic             start_hit;
    logic             end_hit;

    assign start_hit = pc_valid && (pc == start_addr);
    assign end_hit   = pc_valid && (pc == end_addr);
    assign run_inc   = (run_q == SAT) ? SAT : run_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= WIN_IDLE;
            run_q     <= '0;
            meas_done <= 1'b0;
            meas_val  <= '0;
        end else begin
            meas_done <= 1'b0;
            case (state_q)
                WIN_IDLE: begin
                    if (start_hit) begin
                        state_q <= WIN_TIMING;
                        run_q   <= '0;
                    end
                end
                default: begin
                    if (end_hit) begin
                        meas_done <= 1'b1;
                        meas_val  <= run_inc;
                        state_q   <= WIN_IDLE;
                    end else if (start_hit) begin
                        run_q <= '0;
                    end else begin
                        run_q <= run_inc;
                    end
                end
            endcase
        end
    end

    // R3: a completed measurement needs an open section
    assert_done_needs_timing_R3: assert property (@(posedge clk) disable iff (rst)
        meas_done |-> $past(state_q == WIN_TIMING));

    // R4: a repeated start restarts the count
    assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_TIMING && start_hit && !end_hit) |=> (run_q == '0));

    // R8: the running count never wraps
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_TIMING && !start_hit && !end_hit) |=> (run_q >= $past(run_q)));
endmodule

// File: rtl/cprof_stats.sv
module cprof_stats
    import cprof_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             meas_done,
    input  logic [CNT_W-1:0] meas_val,
    output logic [CNT_W-1:0] last_q,
    output logic [CNT_W-1:0] min_q,
    output logic [CNT_W-1:0] max_q,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] total_q,
    output logic             upd_q
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    logic [CNT_W:0] sum;

    assign sum = {1'b0, total_q} + {1'b0, meas_val};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            last_q  <= '0;
            min_q   <= SAT;
            max_q   <= '0;
            count_q <= '0;
            total_q <= '0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= meas_done;
            if (meas_done) begin
                last_q  <= meas_val;
                if (meas_val < min_q) min_q <= meas_val;
                if (meas_val > max_q) max_q <= meas_val;
                count_q <= (count_q == SAT) ? SAT : count_q + 1'b1;
                total_q <= sum[CNT_W] ? SAT : sum[CNT_W-1:0];
            end
        end
    end

    // R1: clear empties the statistics
    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count_q == '0 && min_q == SAT && max_q == '0 && total_q == '0));

    // R5: once any measurement exists, min never exceeds max
    assert_min_le_max_R5: assert property (@(posedge clk) disable iff (rst)
        (count_q != '0) |-> (min_q <= max_q));

    // R6: the trigger count moves by at most one per cycle unless cleared
    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

    // R8: the sum is never below the latest measurement
    assert_total_ge_last_R8: assert property (@(posedge clk) disable iff (rst)
        total_q >= last_q);
endmodule

// File: rtl/cprof_divider.sv
module cprof_divider
    import cprof_pkg::*;
#(
    parameter int unsigned W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         abort,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         done
);
    localparam int unsigned STEP_W = $clog2(W) + 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(W - 1);

    div_state_e        state_q;
    logic [W-1:0]      rem_q;
    logic [W-1:0]      dvs_q;
    logic [STEP_W-1:0] step_q;
    logic [W:0]        trial;
    logic [W:0]        diff;
    logic              fits;

    assign trial = {rem_q, quotient[W-1]};
    assign diff  = trial - {1'b0, dvs_q};
    assign fits  = trial >= {1'b0, dvs_q};

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state_q  <= DIV_IDLE;
            rem_q    <= '0;
            dvs_q    <= '0;
            step_q   <= '0;
            quotient <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state_q  <= DIV_RUN;
                rem_q    <= '0;
                dvs_q    <= divisor;
                quotient <= dividend;
                step_q   <= '0;
            end else if (state_q == DIV_RUN) begin
                rem_q    <= fits ? diff[W-1:0] : trial[W-1:0];
                quotient <= {quotient[W-2:0], fits};
                step_q   <= step_q + 1'b1;
                if (step_q == LAST_STEP) begin
                    state_q <= DIV_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end

    // R7: the divider only reports completion at the end of a run
    assert_done_after_run_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state_q == DIV_RUN));

    // R7: the step counter stays inside one division
    assert_step_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == DIV_RUN) |-> (step_q <= LAST_STEP));
endmodule

// File: rtl/section_profiler.sv
module section_profiler
    import cprof_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_valid,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic              stats_clr,
    output logic [CNT_W-1:0]  last_cycles,
    output logic [CNT_W-1:0]  min_cycles,
    output logic [CNT_W-1:0]  max_cycles,
    output logic [CNT_W-1:0]  trig_count,
    output logic [CNT_W-1:0]  total_cycles,
    output logic [CNT_W-1:0]  avg_cycles,
    output logic              avg_valid
);
    logic             meas_done;
    logic [CNT_W-1:0] meas_val;
    logic             upd;
    logic [CNT_W-1:0] quo;
    logic             div_done;

    cprof_window #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_window (
        .clk        (clk),
        .rst        (rst),
        .pc_valid   (pc_valid),
        .pc         (pc),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .meas_done  (meas_done),
        .meas_val   (meas_val)
    );

    cprof_stats #(.CNT_W(CNT_W)) u_stats (
        .clk       (clk),
        .rst       (rst),
        .clr       (stats_clr),
        .meas_done (meas_done),
        .meas_val  (meas_val),
        .last_q    (last_cycles),
        .min_q     (min_cycles),
        .max_q     (max_cycles),
        .count_q   (trig_count),
        .total_q   (total_cycles),
        .upd_q     (upd)
    );

    cprof_divider #(.W(CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .abort    (stats_clr),
        .start    (upd),
        .dividend (total_cycles),
        .divisor  (trig_count),
        .quotient (quo),
        .done     (div_done)
    );

    always_ff @(posedge clk) begin
        if (rst || stats_clr) begin
            avg_cycles <= '0;
            avg_valid  <= 1'b0;
        end else if (upd) begin
            avg_valid <= 1'b0;
        end else if (div_done) begin
            avg_cycles <= quo;
            avg_valid  <= 1'b1;
        end
    end

    // R7: the mean becomes valid only right after the divider finishes
    assert_valid_after_div_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(avg_valid) |-> $past(div_done));

    // R7: a valid mean implies at least one measurement
    assert_valid_has_count_R7: assert property (@(posedge clk) disable iff (rst)
        avg_valid |-> (trig_count != '0));
endmodule

// File: tb/section_profiler_bench.sv
module section_profiler_bench;
    localparam int AW   = 16;
    localparam int CW   = 10;
    localparam longint MAXV = (64'd1 << CW) - 1;
    localparam logic [AW-1:0] S_ADDR = 16'hA004;
    localparam logic [AW-1:0] E_ADDR = 16'hA008;

    typedef struct {
        longint last;
        longint mn;
        longint mx;
        longint cnt;
        longint tot;
        longint avg;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pc_valid = 1'b0;
    logic [AW-1:0] pc = '0;
    logic          stats_clr = 1'b0;
    logic [CW-1:0] last_cycles, min_cycles, max_cycles, trig_count, total_cycles, avg_cycles;
    logic          avg_valid;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    longint m_last, m_min, m_max, m_cnt, m_tot;
    logic prev_v = 1'b0;
    bit   done_flag = 1'b0;

    always #2.5 clk = ~clk;

    section_profiler #(.ADDR_W(AW), .CNT_W(CW)) u_section_profiler (
        .clk (clk), .rst (rst), .pc_valid (pc_valid), .pc (pc),
        .start_addr (S_ADDR), .end_addr (E_ADDR), .stats_clr (stats_clr),
        .last_cycles (last_cycles), .min_cycles (min_cycles), .max_cycles (max_cycles),
        .trig_count (trig_count), .total_cycles (total_cycles),
        .avg_cycles (avg_cycles), .avg_valid (avg_valid)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_last = 0; m_min = MAXV; m_max = 0; m_cnt = 0; m_tot = 0;
    endtask

    task automatic model_add(input longint n);
        exp_t e;
        longint m;
        m = (n > MAXV) ? MAXV : n;
        m_last = m;
        if (m < m_min) m_min = m;
        if (m > m_max) m_max = m;
        m_cnt = (m_cnt == MAXV) ? MAXV : m_cnt + 1;
        m_tot = (m_tot + m > MAXV) ? MAXV : m_tot + m;
        e.last = m_last; e.mn = m_min; e.mx = m_max;
        e.cnt = m_cnt; e.tot = m_tot; e.avg = m_tot / m_cnt;
        q.push_back(e);
    endtask

    task automatic filler(input int mode, input int i);
        case (mode)
            0: begin pc_valid = 1'b1; pc = 16'h1000; end
            1: begin pc_valid = 1'b1; pc = (i % 2 == 1) ? 16'hA006 : 16'hA00A; end
            default: begin pc_valid = 1'b0; pc = (i % 2 == 1) ? S_ADDR : E_ADDR; end
        endcase
    endtask

    // pre > 0 opens a section pre cycles before the restart (R4)
    task automatic measure(input int pre, input int n, input int mode);
        if (pre > 0) begin
            @(negedge clk); pc_valid = 1'b1; pc = S_ADDR;
            for (int i = 1; i < pre; i++) begin @(negedge clk); filler(mode, i); end
        end
        @(negedge clk); pc_valid = 1'b1; pc = S_ADDR;
        for (int i = 1; i < n; i++) begin @(negedge clk); filler(mode, i); end
        @(negedge clk); pc_valid = 1'b1; pc = E_ADDR;
        model_add(n);
        @(negedge clk); pc_valid = 1'b0; pc = '0;
        repeat (CW + 2) @(negedge clk);
        chk("R7 avg_valid low while dividing", avg_valid, 0);
        @(negedge clk);
        chk("R7 avg_valid rises on schedule", avg_valid, 1);
        repeat (2) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && avg_valid && !prev_v) begin
            if (q.size() == 0) begin
                chk("R6 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R2 R6 last_cycles", last_cycles, e.last);
                chk("R5 min_cycles", min_cycles, e.mn);
                chk("R5 max_cycles", max_cycles, e.mx);
                chk("R6 R8 trig_count", trig_count, e.cnt);
                chk("R6 R8 total_cycles", total_cycles, e.tot);
                chk("R7 avg_cycles", avg_cycles, e.avg);
            end
        end
        prev_v = avg_valid;
    end

    task automatic check_idle(input string tag);
        chk({tag, " min"}, min_cycles, MAXV);
        chk({tag, " max"}, max_cycles, 0);
        chk({tag, " last"}, last_cycles, 0);
        chk({tag, " count"}, trig_count, 0);
        chk({tag, " total"}, total_cycles, 0);
        chk({tag, " avg"}, avg_cycles, 0);
        chk({tag, " avg_valid"}, avg_valid, 0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        model_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 reset");

        measure(0, 12, 0);   // R2 plain filler
        measure(0, 5, 1);    // R2 loop body passes
        measure(0, 20, 2);   // R2 R3 invalid cycles carrying addresses
        measure(0, 1, 0);    // R2 shortest section
        measure(7, 9, 1);    // R4 restart midway

        // R3: lone end address, no section open
        @(negedge clk); pc_valid = 1'b1; pc = E_ADDR;
        @(negedge clk); pc_valid = 1'b0; pc = '0;
        repeat (CW + 8) @(negedge clk);
        chk("R3 count unchanged after lone end", trig_count, m_cnt);
        chk("R3 avg_valid kept after lone end", avg_valid, 1);

        // R1: clear
        @(negedge clk); stats_clr = 1'b1;
        @(negedge clk); stats_clr = 1'b0;
        check_idle("R1 clear");
        model_clear();

        measure(0, 30, 0);
        measure(0, 3, 2);

        // R8: section longer than the counter range
        measure(0, 1100, 0);
        chk("R8 measurement saturates", last_cycles, MAXV);

        // R8: count and sum saturation
        @(negedge clk); stats_clr = 1'b1;
        @(negedge clk); stats_clr = 1'b0;
        model_clear();
        for (int k = 0; k < 1030; k++) measure(0, 2, 0);
        chk("R8 trig_count saturated", trig_count, MAXV);
        chk("R8 total saturated", total_cycles, MAXV);
        chk("R6 scoreboard drained", q.size(), 0);
        finish_run();
    end
endmodule